// File: doc/BRIEF.md
# Energy Accumulator with Emulated Reactive Load

This block turns a stream of paired voltage and current samples into active energy. Each accepted pair is multiplied, and the signed product is added into a wide accumulator. When the accumulated energy reaches a programmable threshold, the block emits a single-clock energy pulse and subtracts the threshold. The remainder is kept, so the pulse rate stays proportional to energy.

For phase calibration with only a resistive test load, calibration mode routes one channel through a delay line. The delay is a whole number of samples, from 0 to 7. A lag of N samples shifts that channel by an angle of 2π·N·f_mains/f_sample, so the effective power factor drops to the cosine of that angle. For example, N = 3 at 50 Hz mains and about 995 Hz sampling gives roughly 54°. The chosen angle should be large enough for small phase errors to be measurable, but should leave the power factor well above zero.

A controller sequences the work through five named states:
- ST_FLUSH clears the delay line and the accumulator. It is entered from reset and on a configuration change, and always moves to ST_WAIT.
- ST_WAIT either moves to ST_FLUSH when the mode, lag or channel inputs differ from the stored configuration, or moves to ST_MULT when a valid sample is accepted, or stays in ST_WAIT.
- ST_MULT forms the product and moves to ST_ACCUM.
- ST_ACCUM adds the product and moves to ST_CHECK.
- ST_CHECK compares the total against the threshold and returns to ST_WAIT.

Top module: `energy_lag_meter`

## Requirements
- R1: After reset, `energy_acc` is 0 and `energy_pulse` is low.
- R2: A sample pair accepted while the block is in ST_WAIT has its product added to `energy_acc` as a signed value. The new total is visible after the fourth rising clock edge following acceptance.
- R3: With `calib_en`=1 and `lag_count`=N (N from 1 to 7), the delayed channel uses the value accepted N samples earlier. Before N samples have been accepted since the last flush, that value is 0. N=3 is a supported setting.
- R4: `lag_on_volt`=0 delays the current channel. `lag_on_volt`=1 delays the voltage channel. The other channel is always used undelayed.
- R5: With `calib_en`=0, neither channel is delayed, whatever the value of `lag_count`.
- R6: Any change to `calib_en`, `lag_count` or `lag_on_volt` seen in ST_WAIT flushes the delay line and clears `energy_acc` to 0 within two clock edges.
- R7: If, after an add, `energy_acc` is at or above a nonzero `pulse_thresh`, the threshold is subtracted once (the remainder is kept) and `energy_pulse` is high for exactly one clock, starting at the same fourth edge.
- R8: Negative products lower the total. No pulse is issued while the total is below the threshold, including while it is negative.
- R9: A `pulse_thresh` of 0 disables pulses, and the total is not reduced.
- R10: `smp_valid` asserted during the three cycles after an acceptance (ST_MULT, ST_ACCUM, ST_CHECK) has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample pair present |
| volt_smp | input | 16 | Signed voltage sample |
| curr_smp | input | 16 | Signed current sample |
| calib_en | input | 1 | 1 = calibration mode, delay line active |
| lag_count | input | 3 | Delay in samples, N |
| lag_on_volt | input | 1 | 1 = delay voltage, 0 = delay current |
| pulse_thresh | input | 40 | Energy per pulse; 0 disables pulses |
| energy_pulse | output | 1 | One-clock energy pulse |
| energy_acc | output | 48 | Signed accumulated energy |

## Verification
The assertions assume the following about the inputs:
- `pulse_thresh` does not change between an add and the comparison that follows it.
- The configuration inputs change only while the block is idle in ST_WAIT.

The stimulus meets these conditions:
- It changes the configuration only after a sample has fully completed.
- It sets the threshold only between samples.
- It offers a new pair only after the previous pulse window has closed.

The one deliberate exception is a second `smp_valid` held during ST_MULT, which checks that the block ignores it.

// File: rtl/eacc_pkg.sv
package eacc_pkg;
    typedef enum logic [2:0] {
        ST_FLUSH,
        ST_WAIT,
        ST_MULT,
        ST_ACCUM,
        ST_CHECK
    } ctrl_state_t;
endpackage

// File: rtl/eacc_lag_line.sv
module eacc_lag_line #(
    parameter int SMP_W   = 16,
    parameter int MAX_LAG = 7,
    parameter int LAG_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    shift,
    input  logic signed [SMP_W-1:0] din,
    input  logic [LAG_W-1:0]        lag,
    output logic signed [SMP_W-1:0] dout
);
    logic signed [SMP_W-1:0] taps [MAX_LAG];

    // One register per delay step.
    for (genvar k = 0; k < MAX_LAG; k++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                taps[k] <= '0;
            end else if (flush) begin
                taps[k] <= '0;
            end else if (shift) begin
                if (k == 0) begin
                    taps[k] <= din;
                end else begin
                    taps[k] <= taps[k-1];
                end
            end
        end
    end

    // A lag of 0 passes the input straight through.
    always_comb begin
        dout = din;
        for (int k = 0; k < MAX_LAG; k++) begin
            if (int'(lag) == k + 1) begin
                dout = taps[k];
            end
        end
    end

    AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (taps[0] == '0 && taps[MAX_LAG-1] == '0)); // R6
endmodule

// File: rtl/eacc_mac.sv
module eacc_mac #(
    parameter int SMP_W = 16,
    parameter int ACC_W = 48,
    parameter int THR_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    load,
    input  logic                    mul,
    input  logic                    add,
    input  logic                    chk,
    input  logic signed [SMP_W-1:0] v_in,
    input  logic signed [SMP_W-1:0] i_in,
    input  logic [THR_W-1:0]        thr,
    output logic signed [ACC_W-1:0] acc,
    output logic                    pulse
);
    localparam int PROD_W = 2 * SMP_W;

    logic signed [SMP_W-1:0]  v_q, i_q;
    logic signed [PROD_W-1:0] prod_q;
    logic signed [ACC_W-1:0]  prod_ext, thr_ext;

    // Sign-extend the product; zero-extend the unsigned threshold.
    assign prod_ext = {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
    assign thr_ext  = $signed({{(ACC_W-THR_W){1'b0}}, thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= '0;
            i_q    <= '0;
            prod_q <= '0;
            acc    <= '0;
            pulse  <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (flush) begin
                v_q    <= '0;
                i_q    <= '0;
                prod_q <= '0;
                acc    <= '0;
            end else begin
                if (load) begin
                    v_q <= v_in;
                    i_q <= i_in;
                end
                if (mul) begin
                    prod_q <= v_q * i_q;
                end
                if (add) begin
                    acc <= acc + prod_ext;
                end
                if (chk && (thr != '0) && (acc >= thr_ext)) begin
                    acc   <= acc - thr_ext;
                    pulse <= 1'b1;
                end
            end
        end
    end

    AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (acc == '0)); // R6
    AST_PULSE_AT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> ($past(acc) >= $signed({{(ACC_W-THR_W){1'b0}}, thr}))); // R8
    AST_ZERO_THR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk && thr == '0) |=> !pulse); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush || add || chk) |=> $stable(acc)); // R2
endmodule

// File: rtl/eacc_ctrl.sv
module eacc_ctrl
    import eacc_pkg::*;
#(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [CFG_W-1:0] cfg_in,
    output logic             flush,
    output logic             take,
    output logic             do_mul,
    output logic             do_add,
    output logic             do_chk
);
    ctrl_state_t      state_q, state_d;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_moved;

    assign cfg_moved = (cfg_in != cfg_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: state_d = ST_WAIT;
            ST_WAIT: begin
                if (cfg_moved) begin
                    state_d = ST_FLUSH;
                end else if (smp_valid) begin
                    state_d = ST_MULT;
                end
            end
            ST_MULT:  state_d = ST_ACCUM;
            ST_ACCUM: state_d = ST_CHECK;
            ST_CHECK: state_d = ST_WAIT;
            default:  state_d = ST_FLUSH;
        endcase
    end

    // State and stored-configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLUSH;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && cfg_moved) begin
                cfg_q <= cfg_in;
            end
        end
    end

    // Strobes decoded from the current state.
    always_comb begin
        flush  = 1'b0;
        take   = 1'b0;
        do_mul = 1'b0;
        do_add = 1'b0;
        do_chk = 1'b0;
        unique case (state_q)
            ST_FLUSH: flush  = 1'b1;
            ST_WAIT:  take   = smp_valid && !cfg_moved;
            ST_MULT:  do_mul = 1'b1;
            ST_ACCUM: do_add = 1'b1;
            ST_CHECK: do_chk = 1'b1;
            default:  flush  = 1'b1;
        endcase
    end

    AST_FLUSH_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_WAIT)); // R6
    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!take && state_q == ST_MULT)); // R10
    AST_CFG_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cfg_moved) |=> (state_q == ST_FLUSH)); // R6
endmodule

// File: rtl/energy_lag_meter.sv
module energy_lag_meter #(
    parameter int SMP_W   = 16,
    parameter int ACC_W   = 48,
    parameter int THR_W   = 40,
    parameter int MAX_LAG = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] volt_smp,
    input  logic signed [SMP_W-1:0] curr_smp,
    input  logic                    calib_en,
    input  logic [$clog2(MAX_LAG+1)-1:0] lag_count,
    input  logic                    lag_on_volt,
    input  logic [THR_W-1:0]        pulse_thresh,
    output logic                    energy_pulse,
    output logic signed [ACC_W-1:0] energy_acc
);
    localparam int LAG_W = $clog2(MAX_LAG + 1);
    localparam int CFG_W = LAG_W + 2;

    logic                    flush, take, do_mul, do_add, do_chk;
    logic [LAG_W-1:0]        lag_eff;
    logic signed [SMP_W-1:0] line_in, line_out, v_pair, i_pair;

    // Outside calibration mode the lag is forced to zero.
    assign lag_eff = calib_en ? lag_count : '0;

    // The selected channel goes through the delay line.
    assign line_in = lag_on_volt ? volt_smp : curr_smp;
    assign v_pair  = lag_on_volt ? line_out : volt_smp;
    assign i_pair  = lag_on_volt ? curr_smp : line_out;

    eacc_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .cfg_in   ({calib_en, lag_on_volt, lag_count}),
        .flush    (flush),
        .take     (take),
        .do_mul   (do_mul),
        .do_add   (do_add),
        .do_chk   (do_chk)
    );

    eacc_lag_line #(.SMP_W(SMP_W), .MAX_LAG(MAX_LAG), .LAG_W(LAG_W)) u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(flush),
        .shift(take),
        .din  (line_in),
        .lag  (lag_eff),
        .dout (line_out)
    );

    eacc_mac #(.SMP_W(SMP_W), .ACC_W(ACC_W), .THR_W(THR_W)) u_mac (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(flush),
        .load (take),
        .mul  (do_mul),
        .add  (do_add),
        .chk  (do_chk),
        .v_in (v_pair),
        .i_in (i_pair),
        .thr  (pulse_thresh),
        .acc  (energy_acc),
        .pulse(energy_pulse)
    );
endmodule

// File: tb/energy_lag_meter_test.sv
module energy_lag_meter_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] volt_smp = '0;
    logic signed [15:0] curr_smp = '0;
    logic               calib_en = 1'b0;
    logic [2:0]         lag_count = '0;
    logic               lag_on_volt = 1'b0;
    logic [39:0]        pulse_thresh = '0;
    logic               energy_pulse;
    logic signed [47:0] energy_acc;

    int     n_checks = 0;
    int     n_fail = 0;
    bit     done = 1'b0;

    // Reference model state.
    longint     m_acc = 0;
    int         m_hist [8];
    int         m_lag = 0;
    bit         m_vol = 1'b0;

    always #5 clk = ~clk;

    energy_lag_meter uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .volt_smp(volt_smp), .curr_smp(curr_smp),
        .calib_en(calib_en), .lag_count(lag_count), .lag_on_volt(lag_on_volt),
        .pulse_thresh(pulse_thresh),
        .energy_pulse(energy_pulse), .energy_acc(energy_acc)
    );

    task automatic check(input string req, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // R6: apply a configuration, then expect an empty line and a zero total.
    task automatic set_cfg(input bit cal, input int lag, input bit vol);
        calib_en    = cal;
        lag_count   = 3'(lag);
        lag_on_volt = vol;
        m_lag = cal ? lag : 0;
        m_vol = vol;
        m_acc = 0;
        for (int j = 0; j < 8; j++) m_hist[j] = 0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R6 flush clears total", longint'(energy_acc), 0);
    endtask

    // One sample pair; hold_extra keeps valid high with other data during ST_MULT (R10).
    task automatic send(input int v, input int i, input bit hold_extra, input string req);
        int     x, d, vv, ii;
        bit     exp_p;
        x = m_vol ? v : i;
        d = (m_lag == 0) ? x : m_hist[m_lag-1];
        for (int j = 7; j > 0; j--) m_hist[j] = m_hist[j-1];
        m_hist[0] = x;
        vv = m_vol ? d : v;
        ii = m_vol ? i : d;
        m_acc = m_acc + longint'(vv) * longint'(ii);
        exp_p = (pulse_thresh != 0) && (m_acc >= longint'(pulse_thresh));
        if (exp_p) m_acc = m_acc - longint'(pulse_thresh);

        volt_smp  = 16'(v);
        curr_smp  = 16'(i);
        smp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (hold_extra) begin
            volt_smp = 16'(12345);
            curr_smp = 16'(-777);
        end else begin
            smp_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check({req, " pulse"}, longint'(energy_pulse), longint'(exp_p));
        check({req, " total"}, longint'(energy_acc), m_acc);
        @(posedge clk);
        @(negedge clk);
        check("R7 pulse one clock", longint'(energy_pulse), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset total", longint'(energy_acc), 0);
        check("R1 reset pulse", longint'(energy_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int j = 0; j < 8; j++) m_hist[j] = 0;

        // Sweep all mode / channel / lag combinations (R2 R3 R4 R5 R7).
        pulse_thresh = 40'd30000000;
        for (int cal = 0; cal < 2; cal++) begin
            for (int vol = 0; vol < 2; vol++) begin
                for (int n = 0; n < 8; n++) begin
                    set_cfg(bit'(cal), n, bit'(vol));
                    for (int k = 0; k < 10; k++) begin
                        send((k * 7919 + n * 1013) % 20000 - 9000,
                             (k * 4391 + vol * 2111) % 18000 - 8000, 1'b0,
                             cal != 0 ? (vol != 0 ? "R3 R4 lag on voltage" : "R3 R4 lag on current")
                                      : "R2 R5 no lag");
                    end
                end
            end
        end

        // R3: N=3 with a recognisable ramp.
        set_cfg(1'b1, 3, 1'b0);
        for (int k = 1; k <= 6; k++) send(1000, k * 100, 1'b0, "R3 lag of three");

        // R8: negative energy never pulses.
        set_cfg(1'b0, 0, 1'b0);
        for (int k = 0; k < 6; k++) send(20000, -15000, 1'b0, "R8 negative total");
        for (int k = 0; k < 6; k++) send(30000, 30000, 1'b0, "R8 climb back");

        // R9: zero threshold disables pulses.
        pulse_thresh = '0;
        for (int k = 0; k < 4; k++) send(32000, 32000, 1'b0, "R9 zero threshold");

        // R7: small threshold, remainder kept.
        pulse_thresh = 40'd1000;
        set_cfg(1'b0, 1, 1'b0);
        for (int k = 0; k < 5; k++) send(30, 20 + k, 1'b0, "R7 remainder kept");

        // R10: valid held during the busy cycles is ignored.
        set_cfg(1'b1, 2, 1'b1);
        pulse_thresh = 40'd50000000;
        for (int k = 0; k < 8; k++) send(k * 3000 - 9000, 5000 - k * 700, 1'b1, "R10 busy valid ignored");

        done = 1'b1;
        summary();
    end
endmodule